// File: doc/BRIEF.md
# Transmit Jabber Lockout Controller

This block protects a shared medium from a station that keeps its transmitter on for too long. It counts how many consecutive clock cycles the transmit activity input stays high. If that count reaches a configured jabber limit, the block turns off the driver enable and raises a lockout flag. The flag asks the station-side logic to send a collision indication. A driver-fault input and an external redundant-jabber disable input also force the same lockout, one cycle after either is seen.

Once locked, the block only lets the driver back on after a long quiet interval. A quiet cycle is one in which transmit is idle, no fault is present and the external disable is low. The release needs an unbroken run of such cycles. Any transmit activity, fault or external disable during that run sends the count back to zero, and the flag stays asserted throughout. Both limits are parameters in clock cycles. At a 10 MHz timebase the nominal values are 26 ms for the jabber limit and 400 ms for the quiet interval.

Top module: `jabber_lockout`

## Requirements
- R1: After reset, drv_enable is 1 and lockout is 0.
- R2: When tx_active is high in the running state for JAB_CYCLES consecutive sampled cycles, lockout goes to 1 and drv_enable goes to 0 after the clock edge that samples the last of those cycles.
- R3: A cycle with tx_active low in the running state restarts the jabber count. Repeated bursts of JAB_CYCLES-1 active cycles separated by idle cycles never cause a lockout.
- R4: A high drv_fault or ext_disable sampled in the running state causes lockout 1 and drv_enable 0 after that clock edge.
- R5: While locked, lockout stays 1 and drv_enable stays 0 for every cycle until the release of R6, whatever tx_active, drv_fault or ext_disable do.
- R6: The lock is released (lockout 0, drv_enable 1) after the edge that samples the UNJAB_CYCLES-th consecutive quiet cycle. A quiet cycle has tx_active, drv_fault and ext_disable all 0. A non-quiet cycle resets this count to zero.
- R7: After a release, the jabber count starts from zero, so a following burst needs a full JAB_CYCLES active cycles to lock again.
- R8: drv_enable and lockout are always complements of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock that counts both intervals |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_active | input | 1 | Transmit activity from the station |
| drv_fault | input | 1 | Driver fault indication |
| ext_disable | input | 1 | External redundant-jabber disable |
| drv_enable | output | 1 | Enable for the transmit driver |
| lockout | output | 1 | Lockout flag, requests the collision signal |

## Verification
The hardest case to reach from the ports is a release attempt that is cut off one cycle short. This means a run of exactly UNJAB_CYCLES-1 quiet cycles followed by a single active or fault cycle, after which a full new run is still required. Random bursts seldom line up on that exact cycle, so directed sequences drive exactly that near-miss. They also drive a jabber burst one cycle short of the limit, and a full-length burst right after a release. Randomly sized bursts, idle gaps and rare faults are then compared cycle by cycle against a reference model in the bench.

// File: rtl/jl_pkg.sv
package jl_pkg;
    typedef enum logic {
        JL_RUN  = 1'b0,
        JL_LOCK = 1'b1
    } jl_mode_e;

    typedef struct packed {
        jl_mode_e mode;
    } jl_ctrl_s;
endpackage

// File: rtl/jl_run_counter.sv
// Counts consecutive cycles with count_en high; hit pulses on the LIMIT-th.
module jl_run_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_s;

    cnt_s cur_q, nxt_d;

    assign hit = count_en && (cur_q.cnt == W'(LIMIT - 1));

    always_comb begin
        nxt_d = cur_q;
        if (!count_en) begin
            nxt_d.cnt = '0;
        end else if (hit) begin
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt < W'(LIMIT)); // R3
    AST_HIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cur_q.cnt == '0)); // R7
endmodule

// File: rtl/jabber_lockout.sv
module jabber_lockout #(
    parameter int JAB_CYCLES   = 260000,
    parameter int UNJAB_CYCLES = 4000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    input  logic drv_fault,
    input  logic ext_disable,
    output logic drv_enable,
    output logic lockout
);
    import jl_pkg::*;

    jl_ctrl_s ctl_q, ctl_d;
    logic     running;
    logic     force_lock;
    logic     quiet;
    logic     jab_hit;
    logic     unjab_hit;

    assign running    = (ctl_q.mode == JL_RUN);
    assign force_lock = drv_fault || ext_disable;
    assign quiet      = !tx_active && !force_lock;

    // Consecutive-activity measurement while the driver is allowed on.
    jl_run_counter #(.LIMIT(JAB_CYCLES)) u_jab_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (running && tx_active),
        .hit      (jab_hit)
    );

    // Unbroken quiet interval needed before the driver comes back.
    jl_run_counter #(.LIMIT(UNJAB_CYCLES)) u_unjab_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (!running && quiet),
        .hit      (unjab_hit)
    );

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.mode)
            JL_RUN:  if (force_lock || jab_hit) ctl_d.mode = JL_LOCK;
            JL_LOCK: if (unjab_hit)             ctl_d.mode = JL_RUN;
            default: ctl_d.mode = JL_LOCK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.mode <= JL_RUN;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign drv_enable = running;
    assign lockout    = !running;

    AST_FORCE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_enable && force_lock) |=> lockout); // R4
    AST_JAB_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_enable && jab_hit) |=> (lockout && !drv_enable)); // R2
    AST_HOLD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (lockout && !quiet) |=> lockout); // R5
    AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lockout) |-> $past(unjab_hit)); // R6
endmodule

// File: tb/tb_jabber_lockout.sv
module tb_jabber_lockout;
    localparam int JAB   = 20;
    localparam int UNJAB = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_active = 1'b0;
    logic drv_fault = 1'b0;
    logic ext_disable = 1'b0;
    logic drv_enable;
    logic lockout;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference model state
    bit m_lock = 1'b0;
    int m_jc = 0;
    int m_uc = 0;

    always #10 clk = ~clk;

    jabber_lockout #(.JAB_CYCLES(JAB), .UNJAB_CYCLES(UNJAB)) dut (
        .clk(clk), .rst_n(rst_n), .tx_active(tx_active),
        .drv_fault(drv_fault), .ext_disable(ext_disable),
        .drv_enable(drv_enable), .lockout(lockout)
    );

    function automatic bit is_quiet(bit t, bit f, bit e);
        return !t && !f && !e;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_lock = 1'b0; m_jc = 0; m_uc = 0;
        end else if (!m_lock) begin
            if (drv_fault || ext_disable) begin
                m_lock = 1'b1; m_jc = 0;
            end else if (tx_active) begin
                if (m_jc == JAB - 1) begin m_lock = 1'b1; m_jc = 0; end
                else m_jc++;
            end else m_jc = 0;
        end else begin
            if (is_quiet(tx_active, drv_fault, ext_disable)) begin
                if (m_uc == UNJAB - 1) begin m_lock = 1'b0; m_uc = 0; end
                else m_uc++;
            end else m_uc = 0;
        end
        if (cycles > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: run did not end, actual cycles %0d expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(string req);
        checks++;
        if (drv_enable !== !m_lock || lockout !== m_lock) begin
            fails++;
            $display("FAIL %s: actual en=%b lock=%b expected en=%b lock=%b",
                     req, drv_enable, lockout, !m_lock, m_lock);
        end
        if (drv_enable === lockout) begin
            fails++;
            $display("FAIL R8: actual en=%b lock=%b expected complementary", drv_enable, lockout);
        end
    endtask

    task automatic expect_lock(string req, bit exp);
        checks++;
        if (lockout !== exp) begin
            fails++;
            $display("FAIL %s: actual lockout=%b expected %b", req, lockout, exp);
        end
    endtask

    task automatic cyc(bit t, bit f, bit e, string req);
        tx_active = t; drv_fault = f; ext_disable = e;
        @(negedge clk);
        chk(req);
    endtask

    task automatic run(int n, bit t, bit f, bit e, string req);
        for (int i = 0; i < n; i++) cyc(t, f, e, req);
    endtask

    initial begin
        int burst;
        int gap;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1");
        expect_lock("R1", 1'b0);

        // R3: near-limit bursts never lock
        for (int k = 0; k < 3; k++) begin
            run(JAB - 1, 1, 0, 0, "R3");
            run(1, 0, 0, 0, "R3");
        end
        expect_lock("R3", 1'b0);

        // R2: full burst locks on the last sampled cycle
        run(JAB - 1, 1, 0, 0, "R2");
        expect_lock("R2", 1'b0);
        run(1, 1, 0, 0, "R2");
        expect_lock("R2", 1'b1);

        // R5: activity while locked holds lockout
        run(30, 1, 0, 0, "R5");
        expect_lock("R5", 1'b1);

        // R6: near-miss quiet run, then interruption, then full run
        run(UNJAB - 1, 0, 0, 0, "R6");
        expect_lock("R6", 1'b1);
        run(1, 1, 0, 0, "R6");
        run(UNJAB - 1, 0, 0, 0, "R6");
        expect_lock("R6", 1'b1);
        run(1, 0, 0, 0, "R6");
        expect_lock("R6", 1'b0);

        // R7: fresh count after release
        run(JAB - 1, 1, 0, 0, "R7");
        expect_lock("R7", 1'b0);
        run(1, 1, 0, 0, "R7");
        expect_lock("R7", 1'b1);
        run(UNJAB, 0, 0, 0, "R7");
        expect_lock("R7", 1'b0);

        // R4: fault and external disable each lock in one cycle
        run(1, 0, 1, 0, "R4");
        expect_lock("R4", 1'b1);
        run(10, 0, 0, 0, "R5");
        run(1, 0, 1, 0, "R5");
        run(UNJAB - 1, 0, 0, 0, "R5");
        expect_lock("R5", 1'b1);
        run(1, 0, 0, 0, "R6");
        expect_lock("R6", 1'b0);
        run(1, 0, 0, 1, "R4");
        expect_lock("R4", 1'b1);
        run(20, 0, 0, 1, "R5");
        run(UNJAB, 0, 0, 0, "R6");
        expect_lock("R6", 1'b0);

        // Random bursts, gaps and rare faults
        for (int r = 0; r < 120; r++) begin
            burst = 1 + int'($urandom_range(JAB + 5));
            gap   = 1 + int'($urandom_range(UNJAB + 20));
            for (int i = 0; i < burst; i++)
                cyc(1, ($urandom_range(199) == 0), ($urandom_range(299) == 0), "R2");
            for (int i = 0; i < gap; i++)
                cyc(0, ($urandom_range(249) == 0), 0, "R6");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule